// File: doc/BRIEF.md
# Byte-Aliased General Register File

This block holds eight 32-bit general registers behind two combinational read ports and one synchronous write port. Every port carries a register index and a 2-bit access-size code. The size code picks a view: the whole 32-bit register, its low 16-bit half, or one byte of that half.

Registers 0 to 3 are data registers and allow all four views. Registers 4 to 7 are pointer/index registers and allow only the 16-bit and 32-bit views. A byte-sized request that names one of them is flagged as illegal.

A write narrower than 32 bits replaces only the addressed slice and merges it into the stored word. A read places the selected slice in the low bits of its data output and zero-extends it. An execution core uses the block to let narrow operand names share storage with the wide registers.

Top module: `gpr_alias_file`

## Requirements
- R1: A synchronous active-high reset clears all eight registers to zero. Afterwards every 32-bit read returns 0.
- R2: Size code 2'b11 on a read port returns the full 32-bit register for any index from 0 to 7.
- R3: Size code 2'b10 on a read port returns bits 15:0 of the register, zero-extended to 32 bits, for any index.
- R4: For indices 0 to 3, a read with size code 2'b00 returns bits 7:0 of the register, and size code 2'b01 returns bits 15:8. In both cases the byte appears in bits 7:0 of the output, and bits 31:8 are zero.
- R5: A read with size code 2'b00 or 2'b01 and an index from 4 to 7 drives that port's illegal flag high and its data to zero. Every other read has its illegal flag low.
- R6: A write with size code 2'b00 or 2'b01 and an index from 4 to 7 drives `wr_illegal` high in the same cycle and changes no register. `wr_illegal` is low whenever `wr_en` is low.
- R7: A legal write with size code 2'b10, 2'b01 or 2'b00 replaces only the addressed slice. Size 2'b10 takes bits 15:8 and 7:0 from `wr_data[15:0]`. Each byte size takes its byte from `wr_data[7:0]`. All other bits of the register keep their values.
- R8: A read of the register being written in the same cycle returns the value from before the write. The new value is visible from the next cycle on.
- R9: While `wr_en` is low, no register changes, whatever the other write inputs carry.
- R10: The two read ports work independently. Each port returns its own index and view in the same cycle, including when both ports name the same register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write request |
| wr_idx | input | 3 | Write register index |
| wr_size | input | 2 | Write access-size code |
| wr_data | input | 32 | Write data, slice taken from its low bits |
| wr_illegal | output | 1 | Current write request is illegal and is dropped |
| rd_a_idx | input | 3 | Read port A register index |
| rd_a_size | input | 2 | Read port A access-size code |
| rd_a_data | output | 32 | Read port A data, zero-extended slice |
| rd_a_illegal | output | 1 | Read port A request is illegal |
| rd_b_idx | input | 3 | Read port B register index |
| rd_b_size | input | 2 | Read port B access-size code |
| rd_b_data | output | 32 | Read port B data, zero-extended slice |
| rd_b_illegal | output | 1 | Read port B request is illegal |

## Verification
The hardest case to bring about from the ports is a narrow write whose merged result must be checked in bits it never touched. It has to land on a register that already holds a distinctive pattern in every byte, and the result is read back through a different view than the one used for the write.

The stimulus first fills every register with a full write of distinct byte values. It then issues high-byte, low-byte and 16-bit writes. Each is followed by 32-bit and byte reads of the same register, compared against a bench model built from lane masks.

The same-cycle read of the written register gets its own case. So does an illegal byte write to a pointer register, which is followed by a full read of that register.

// File: rtl/gpr_alias_pkg.sv
package gpr_alias_pkg;

  // access-size codes shared by every port
  typedef enum logic [1:0] {
    ACC_LO   = 2'b00,
    ACC_HI   = 2'b01,
    ACC_HALF = 2'b10,
    ACC_FULL = 2'b11
  } acc_size_e;

  localparam int BYTE_W = 8;
  localparam int HALF_W = 16;

  function automatic logic is_byte_size(input logic [1:0] sz);
    return (sz == ACC_LO) || (sz == ACC_HI);
  endfunction

endpackage

// File: rtl/gpr_access_check.sv
module gpr_access_check
  import gpr_alias_pkg::*;
#(
  parameter int NUM_REGS      = 8,
  parameter int NUM_BYTE_REGS = 4,
  localparam int IDX_W        = $clog2(NUM_REGS)
) (
  input  logic [IDX_W-1:0] idx,
  input  logic [1:0]       size,
  output logic             illegal
);

  logic no_byte_view;

  // registers at or above NUM_BYTE_REGS have no byte views
  assign no_byte_view = int'(idx) >= NUM_BYTE_REGS;
  assign illegal      = no_byte_view && is_byte_size(size);

endmodule

// File: rtl/gpr_read_port.sv
module gpr_read_port
  import gpr_alias_pkg::*;
#(
  parameter int DATA_W        = 32,
  parameter int NUM_REGS      = 8,
  parameter int NUM_BYTE_REGS = 4,
  localparam int IDX_W        = $clog2(NUM_REGS)
) (
  input  logic [NUM_REGS-1:0][DATA_W-1:0] file_flat,
  input  logic [IDX_W-1:0]                idx,
  input  logic [1:0]                      size,
  output logic [DATA_W-1:0]               data,
  output logic                            illegal
);

  logic [DATA_W-1:0] word_sel;

  // pick the requested view and zero-extend it
  function automatic logic [DATA_W-1:0] view_extract(input logic [DATA_W-1:0] w,
                                                      input logic [1:0] sz);
    logic [DATA_W-1:0] r;
    case (sz)
      ACC_FULL: r = w;
      ACC_HALF: r = DATA_W'(w[HALF_W-1:0]);
      ACC_HI:   r = DATA_W'(w[HALF_W-1:BYTE_W]);
      default:  r = DATA_W'(w[BYTE_W-1:0]);
    endcase
    return r;
  endfunction

  gpr_access_check #(
    .NUM_REGS     (NUM_REGS),
    .NUM_BYTE_REGS(NUM_BYTE_REGS)
  ) u_chk (
    .idx    (idx),
    .size   (size),
    .illegal(illegal)
  );

  assign word_sel = file_flat[idx];
  assign data     = illegal ? '0 : view_extract(word_sel, size);

  always_comb begin
    if (!illegal && size == ACC_LO)
      AST_BYTE_ZEXT: assert (data[DATA_W-1:BYTE_W] == '0); // R4
  end

endmodule

// File: rtl/gpr_write_merge.sv
module gpr_write_merge
  import gpr_alias_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] old_word,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        size,
  output logic [DATA_W-1:0] new_word
);

  // replace only the addressed slice, keep every other bit
  function automatic logic [DATA_W-1:0] slice_merge(input logic [DATA_W-1:0] o,
                                                     input logic [DATA_W-1:0] d,
                                                     input logic [1:0] sz);
    logic [DATA_W-1:0] r;
    r = o;
    case (sz)
      ACC_FULL: r = d;
      ACC_HALF: r[HALF_W-1:0] = d[HALF_W-1:0];
      ACC_HI:   r[HALF_W-1:BYTE_W] = d[BYTE_W-1:0];
      default:  r[BYTE_W-1:0] = d[BYTE_W-1:0];
    endcase
    return r;
  endfunction

  assign new_word = slice_merge(old_word, wr_data, size);

endmodule

// File: rtl/gpr_alias_file.sv
module gpr_alias_file
  import gpr_alias_pkg::*;
#(
  parameter int DATA_W        = 32,
  parameter int NUM_REGS      = 8,
  parameter int NUM_BYTE_REGS = 4,
  localparam int IDX_W        = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [1:0]        wr_size,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_illegal,
  input  logic [IDX_W-1:0]  rd_a_idx,
  input  logic [1:0]        rd_a_size,
  output logic [DATA_W-1:0] rd_a_data,
  output logic              rd_a_illegal,
  input  logic [IDX_W-1:0]  rd_b_idx,
  input  logic [1:0]        rd_b_size,
  output logic [DATA_W-1:0] rd_b_data,
  output logic              rd_b_illegal
);

  localparam int NUM_RD = 2;

  logic [DATA_W-1:0]              regs_q [NUM_REGS];
  logic [NUM_REGS-1:0][DATA_W-1:0] file_flat;
  logic                           wr_size_bad;
  logic                           wr_commit;
  logic [NUM_REGS-1:0]            wr_hit;

  logic [NUM_RD-1:0][IDX_W-1:0]   rd_idx;
  logic [NUM_RD-1:0][1:0]         rd_size;
  logic [NUM_RD-1:0][DATA_W-1:0]  rd_data;
  logic [NUM_RD-1:0]              rd_ill;

  // write legality
  gpr_access_check #(
    .NUM_REGS     (NUM_REGS),
    .NUM_BYTE_REGS(NUM_BYTE_REGS)
  ) u_wr_chk (
    .idx    (wr_idx),
    .size   (wr_size),
    .illegal(wr_size_bad)
  );

  assign wr_illegal = wr_en && wr_size_bad;
  assign wr_commit  = wr_en && !wr_size_bad;

  // storage, one merge per register
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    logic [DATA_W-1:0] merged;

    assign wr_hit[g] = wr_commit && (int'(wr_idx) == g);

    gpr_write_merge #(.DATA_W(DATA_W)) u_merge (
      .old_word(regs_q[g]),
      .wr_data (wr_data),
      .size    (wr_size),
      .new_word(merged)
    );

    always_ff @(posedge clk) begin
      if (rst)            regs_q[g] <= '0;
      else if (wr_hit[g]) regs_q[g] <= merged;
    end

    assign file_flat[g] = regs_q[g];
  end

  // read ports
  assign rd_idx[0]  = rd_a_idx;
  assign rd_size[0] = rd_a_size;
  assign rd_idx[1]  = rd_b_idx;
  assign rd_size[1] = rd_b_size;

  for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
    gpr_read_port #(
      .DATA_W       (DATA_W),
      .NUM_REGS     (NUM_REGS),
      .NUM_BYTE_REGS(NUM_BYTE_REGS)
    ) u_rd (
      .file_flat(file_flat),
      .idx      (rd_idx[p]),
      .size     (rd_size[p]),
      .data     (rd_data[p]),
      .illegal  (rd_ill[p])
    );
  end

  assign rd_a_data    = rd_data[0];
  assign rd_a_illegal = rd_ill[0];
  assign rd_b_data    = rd_data[1];
  assign rd_b_illegal = rd_ill[1];

  // assertions
  AST_ILLEGAL_WRITE_DROPPED: assert property (@(posedge clk) disable iff (rst)
    wr_illegal |=> $stable(file_flat)); // R6

  AST_IDLE_NO_CHANGE: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(file_flat)); // R9

  AST_HALF_KEEPS_UPPER: assert property (@(posedge clk) disable iff (rst)
    (wr_commit && wr_size == ACC_HALF) |=>
      file_flat[$past(wr_idx)][DATA_W-1:HALF_W] == $past(file_flat[wr_idx][DATA_W-1:HALF_W])); // R7

  AST_BYTE_KEEPS_UPPER: assert property (@(posedge clk) disable iff (rst)
    (wr_commit && is_byte_size(wr_size)) |=>
      file_flat[$past(wr_idx)][DATA_W-1:HALF_W] == $past(file_flat[wr_idx][DATA_W-1:HALF_W])); // R7

  AST_ILLEGAL_READ_ZERO_A: assert property (@(posedge clk) disable iff (rst)
    rd_a_illegal |-> rd_a_data == '0); // R5

  AST_ILLEGAL_READ_ZERO_B: assert property (@(posedge clk) disable iff (rst)
    rd_b_illegal |-> rd_b_data == '0); // R5

endmodule

// File: tb/test_gpr_alias_file.sv
module test_gpr_alias_file;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_idx = '0;
  logic [1:0]  wr_size = '0;
  logic [31:0] wr_data = '0;
  logic        wr_illegal;
  logic [2:0]  rd_a_idx = '0;
  logic [1:0]  rd_a_size = 2'b11;
  logic [31:0] rd_a_data;
  logic        rd_a_illegal;
  logic [2:0]  rd_b_idx = '0;
  logic [1:0]  rd_b_size = 2'b11;
  logic [31:0] rd_b_data;
  logic        rd_b_illegal;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  typedef struct {
    int          kind;      // 0 port A, 1 port B, 2 write flag
    logic [31:0] exp_data;
    logic        exp_ill;
    string       tag;
  } item_t;

  item_t       sb_q[$];
  logic [31:0] model [8];

  always #10 clk = ~clk;  // 50 MHz

  gpr_alias_file i_gpr_alias_file (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_size(wr_size), .wr_data(wr_data),
    .wr_illegal(wr_illegal),
    .rd_a_idx(rd_a_idx), .rd_a_size(rd_a_size), .rd_a_data(rd_a_data), .rd_a_illegal(rd_a_illegal),
    .rd_b_idx(rd_b_idx), .rd_b_size(rd_b_size), .rd_b_data(rd_b_data), .rd_b_illegal(rd_b_illegal)
  );

  // bench model: lane masks
  function automatic logic [31:0] lane_mask(input logic [1:0] sz);
    case (sz)
      2'b11:   return 32'hFFFF_FFFF;
      2'b10:   return 32'h0000_FFFF;
      2'b01:   return 32'h0000_FF00;
      default: return 32'h0000_00FF;
    endcase
  endfunction

  function automatic logic bad_access(input int idx, input logic [1:0] sz);
    return (idx >= 4) && (sz[1] == 1'b0);
  endfunction

  function automatic logic [31:0] model_view(input int idx, input logic [1:0] sz);
    logic [31:0] m;
    if (bad_access(idx, sz)) return 32'h0;
    m = model[idx] & lane_mask(sz);
    if (sz == 2'b01) m = m >> 8;
    return m;
  endfunction

  task automatic push(input int kind, input logic [31:0] d, input logic ill, input string tag);
    item_t it;
    it.kind = kind; it.exp_data = d; it.exp_ill = ill; it.tag = tag;
    sb_q.push_back(it);
  endtask

  // driver: one cycle of stimulus plus expectations
  task automatic cyc(input logic we, input int widx, input logic [1:0] wsz, input logic [31:0] wd,
                     input int aidx, input logic [1:0] asz, input int bidx, input logic [1:0] bsz,
                     input string tag);
    logic [31:0] sh;
    logic        wbad;
    @(negedge clk);
    wr_en = we; wr_idx = 3'(widx); wr_size = wsz; wr_data = wd;
    rd_a_idx = 3'(aidx); rd_a_size = asz; rd_b_idx = 3'(bidx); rd_b_size = bsz;
    wbad = we && bad_access(widx, wsz);
    push(0, model_view(aidx, asz), bad_access(aidx, asz), tag);
    push(1, model_view(bidx, bsz), bad_access(bidx, bsz), tag);
    push(2, 32'h0, wbad, tag);
    if (we && !wbad) begin
      sh = (wsz == 2'b01) ? (wd << 8) : wd;
      model[widx] = (model[widx] & ~lane_mask(wsz)) | (sh & lane_mask(wsz));
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; wr_en = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 8; i++) model[i] = 32'h0;
  endtask

  // monitor: pops and compares away from the clock edge
  always @(negedge clk) begin
    #4;
    while (sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      checks++;
      case (it.kind)
        0: if (rd_a_data !== it.exp_data || rd_a_illegal !== it.exp_ill) begin
             errors++;
             $display("FAIL %s port A: actual data=%h ill=%b expected data=%h ill=%b",
                      it.tag, rd_a_data, rd_a_illegal, it.exp_data, it.exp_ill);
           end
        1: if (rd_b_data !== it.exp_data || rd_b_illegal !== it.exp_ill) begin
             errors++;
             $display("FAIL %s port B: actual data=%h ill=%b expected data=%h ill=%b",
                      it.tag, rd_b_data, rd_b_illegal, it.exp_data, it.exp_ill);
           end
        default: if (wr_illegal !== it.exp_ill) begin
             errors++;
             $display("FAIL %s wr_illegal: actual=%b expected=%b", it.tag, wr_illegal, it.exp_ill);
           end
      endcase
    end
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog R1..: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) model[i] = 32'h0;
    do_reset();

    // R1: everything reads zero after reset
    for (int i = 0; i < 4; i++) cyc(0, 0, 2'b11, 32'hFFFF_FFFF, i, 2'b11, i + 4, 2'b11, "R1");

    // R2: full writes of distinct bytes, then full reads
    for (int i = 0; i < 8; i++)
      cyc(1, i, 2'b11, {8'(8'h10 + i), 8'(8'h80 + i), 8'(8'hC0 + 2 * i), 8'(8'h31 + 3 * i)},
          0, 2'b11, 7, 2'b11, "R2");
    for (int i = 0; i < 4; i++) cyc(0, 0, 2'b00, 32'h0, i, 2'b11, i + 4, 2'b11, "R2");

    // R3: 16-bit views
    for (int i = 0; i < 4; i++) cyc(0, 0, 2'b00, 32'h0, i, 2'b10, i + 4, 2'b10, "R3");

    // R4: byte views of the data registers
    for (int i = 0; i < 4; i++) cyc(0, 0, 2'b00, 32'h0, i, 2'b00, i, 2'b01, "R4");

    // R5: byte views of pointer registers are illegal
    for (int i = 4; i < 8; i++) cyc(0, 0, 2'b00, 32'h0, i, 2'b00, i, 2'b01, "R5");

    // R6: illegal byte writes are flagged and dropped
    cyc(1, 5, 2'b00, 32'h0000_00EE, 5, 2'b11, 6, 2'b11, "R6");
    cyc(1, 7, 2'b01, 32'h0000_00DD, 5, 2'b11, 7, 2'b11, "R6");
    cyc(0, 0, 2'b00, 32'h0, 5, 2'b11, 7, 2'b11, "R6");

    // R7: narrow writes merge
    cyc(1, 1, 2'b01, 32'hABCD_EF5A, 1, 2'b11, 2, 2'b11, "R7");
    cyc(0, 0, 2'b00, 32'h0, 1, 2'b11, 1, 2'b01, "R7");
    cyc(1, 3, 2'b00, 32'h1234_56A7, 3, 2'b11, 1, 2'b00, "R7");
    cyc(0, 0, 2'b00, 32'h0, 3, 2'b11, 3, 2'b01, "R7");
    cyc(1, 6, 2'b10, 32'h7777_9C3E, 6, 2'b11, 3, 2'b00, "R7");
    cyc(0, 0, 2'b00, 32'h0, 6, 2'b11, 6, 2'b10, "R7");
    cyc(1, 2, 2'b10, 32'hFFFF_0001, 0, 2'b11, 2, 2'b01, "R7");
    cyc(0, 0, 2'b00, 32'h0, 2, 2'b11, 2, 2'b00, "R7");

    // R8: same-cycle read sees the old value
    cyc(1, 4, 2'b11, 32'hDEAD_BEEF, 4, 2'b11, 4, 2'b10, "R8");
    cyc(0, 0, 2'b00, 32'h0, 4, 2'b11, 4, 2'b10, "R8");
    cyc(1, 0, 2'b00, 32'h0000_0042, 0, 2'b00, 0, 2'b11, "R8");
    cyc(0, 0, 2'b00, 32'h0, 0, 2'b00, 0, 2'b11, "R8");

    // R9: no write when wr_en is low
    cyc(0, 2, 2'b11, 32'hFFFF_FFFF, 2, 2'b11, 0, 2'b11, "R9");
    cyc(0, 5, 2'b00, 32'h5555_5555, 2, 2'b11, 5, 2'b11, "R9");

    // R10: independent ports, same register and different views
    cyc(0, 0, 2'b00, 32'h0, 3, 2'b01, 3, 2'b10, "R10");
    cyc(0, 0, 2'b00, 32'h0, 7, 2'b10, 1, 2'b00, "R10");

    // R1: reset after data has been written
    do_reset();
    for (int i = 0; i < 4; i++) cyc(0, 0, 2'b00, 32'h0, i, 2'b11, i + 4, 2'b11, "R1");

    @(negedge clk);
    wr_en = 1'b0;
    @(negedge clk);
    #6;
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule